// File: doc/BRIEF.md
# UART Transmit/Receive Buffering with Status Word

This block holds the bytes that pass between a bus and a UART's serial logic in both directions. It also publishes an 8-bit read-only word that describes the state of those buffers. A mode input chooses how much storage each direction has:

- **Holding mode:** each direction behaves as a single-entry holding register.
- **Queue mode:** each direction becomes a first-in first-out queue of `DEPTH` entries.

Changing the mode empties both directions.

A small transmit shifter is included so that the busy indication has cycle-exact timing. The shifter sends:

- one low start bit,
- then the data byte, least significant bit first,
- then `STOP_BITS` high stop bits.

Each bit lasts `BIT_TICKS` clock cycles. The shifter only takes a new byte while the UART enable input is high.

The busy flag rises as soon as any byte is queued, even with the UART disabled. It stays high until the last stop bit has finished.

On the receive side, bytes arrive as single-cycle valid pulses. The bus reads the oldest byte through `rd_data` and strobes `rd_en` to consume it. A byte that arrives when no room is left is lost and sets a sticky overrun indication. A carrier-detect input is mirrored into the status word, or tied off by parameter on instances that have no modem line.

Top module: `uart_buf_flags`

## Requirements
- R1: The status word places receive-full at bit 6, transmit-full at bit 5, receive-empty at bit 4, busy at bit 3 and carrier-detect at bit 2. Bits 7, 1 and 0 always read 0.
- R2: After reset the status word reads 8'h10 (only receive-empty set, with the carrier input low), `overrun` is 0 and `txd` is 1.
- R3: With `fifo_en`=0, one accepted byte makes the matching full flag 1. For receive, it also makes receive-empty 0. Reading that byte returns receive-empty to 1.
- R4: With `fifo_en`=1, transmit-full and receive-full stay 0 until `DEPTH` bytes are held, and read 1 once `DEPTH` bytes are held.
- R5: `rd_data` shows the oldest unread received byte. A `rd_en` pulse removes it, so bytes come out in arrival order.
- R6: A bus write while transmit-full is 1 is dropped and never sent. A receive byte that arrives while receive-full is 1 is dropped and sets `overrun`. `overrun` then stays 1 until the next mode change or reset.
- R7: The cycle after `fifo_en` changes value, both directions are empty: receive-empty is 1, both full flags are 0 and `overrun` is 0. The flushed bytes are never sent or read.
- R8: Busy (bit 3) is 1 in the cycle after a write is accepted, whatever the value of `uart_en`.
- R9: While `uart_en` is 0, `txd` stays 1 and queued bytes wait. While `uart_en` is 1, each queued byte is sent in order as one 0 start bit, 8 data bits LSB first, and `STOP_BITS` 1 stop bits, each held for `BIT_TICKS` cycles.
- R10: Busy stays 1 through the whole final stop bit. For a lone byte written with `uart_en` high, busy is 1 for exactly 1 + (9+`STOP_BITS`)×`BIT_TICKS` consecutive cycles.
- R11: With `HAS_DCD`=1, status bit 2 follows `dcd_in`. With `HAS_DCD`=0, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Buffer mode: 0 holding register, 1 queue; any change flushes |
| uart_en | input | 1 | Allows the shifter to take bytes |
| wr_en | input | 1 | Bus write strobe for transmit data |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Bus read strobe, consumes the oldest received byte |
| rd_data | output | 8 | Oldest received byte |
| rx_valid | input | 1 | Receive byte valid pulse |
| rx_byte | input | 8 | Received byte |
| dcd_in | input | 1 | Carrier-detect input, active high |
| txd | output | 1 | Serial transmit line, idles high |
| status | output | 8 | Flag word |
| overrun | output | 1 | Sticky receive overrun |

## Verification
Some rules are checked by the bound checker on every cycle:

- the reserved status bits stay zero;
- receive-full and receive-empty are never both set;
- an accepted write raises busy on the next cycle;
- transmit-full implies busy, and a low `txd` implies busy;
- `overrun` is sticky;
- a mode change flushes both directions.

Other behaviour is only visible through the bench's scenarios:

- the exact serial frame content and order;
- the precise busy length across the final stop bit;
- that dropped and flushed bytes never appear on `txd`;
- the mode-dependent full thresholds;
- the receive ordering;
- the tied-off carrier bit.

// File: rtl/uart_buf_pkg.sv
package uart_buf_pkg;
    localparam int FLG_RX_FULL  = 6;
    localparam int FLG_TX_FULL  = 5;
    localparam int FLG_RX_EMPTY = 4;
    localparam int FLG_BUSY     = 3;
    localparam int FLG_CARRIER  = 2;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/ubf_queue.sv
module ubf_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         push_drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr_ptr;
        logic [PTR_W-1:0]        rd_ptr;
        logic [CNT_W-1:0]        count;
    } q_state_t;

    q_state_t q_q, q_d;
    logic [CNT_W-1:0] cap;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap       = single ? CNT_W'(1) : CNT_W'(DEPTH);
    assign full      = (q_q.count == cap);
    assign empty     = (q_q.count == '0);
    assign head      = q_q.mem[q_q.rd_ptr];
    assign do_push   = push && !full && !flush;
    assign do_pop    = pop && !empty && !flush;
    assign push_drop = push && full && !flush;

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.wr_ptr = '0;
            q_d.rd_ptr = '0;
            q_d.count  = '0;
        end else begin
            if (do_push) begin
                q_d.mem[q_q.wr_ptr] = push_data;
                q_d.wr_ptr          = ptr_next(q_q.wr_ptr);
            end
            if (do_pop) begin
                q_d.rd_ptr = ptr_next(q_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   q_d.count = q_q.count + 1'b1;
                2'b01:   q_d.count = q_q.count - 1'b1;
                default: q_d.count = q_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/ubf_tx_shift.sv
module ubf_tx_shift
    import uart_buf_pkg::*;
#(
    parameter int W         = 8,
    parameter int BIT_TICKS = 16,
    parameter int STOP_BITS = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         avail,
    input  logic [W-1:0] data,
    output logic         take,
    output logic         active,
    output logic         txd
);
    localparam int FRAME_W = 1 + W + STOP_BITS;
    localparam int TICK_W  = $clog2(BIT_TICKS + 1);
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [TICK_W-1:0]  tick;
        logic [BIT_W-1:0]   bitn;
    } sh_state_t;

    sh_state_t s_q, s_d;

    assign take   = (s_q.st == TX_IDLE) && enable && avail;
    assign active = (s_q.st == TX_SHIFT);
    assign txd    = active ? s_q.sh[0] : 1'b1;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            TX_IDLE: begin
                if (take) begin
                    s_d.st   = TX_SHIFT;
                    s_d.sh   = {{STOP_BITS{1'b1}}, data, 1'b0};
                    s_d.tick = '0;
                    s_d.bitn = '0;
                end
            end
            default: begin
                if (s_q.tick == TICK_W'(BIT_TICKS - 1)) begin
                    s_d.tick = '0;
                    s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
                    if (s_q.bitn == BIT_W'(FRAME_W - 1)) s_d.st = TX_IDLE;
                    else                                 s_d.bitn = s_q.bitn + 1'b1;
                end else begin
                    s_d.tick = s_q.tick + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: TX_IDLE, sh: '1, tick: '0, bitn: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ubf_flags.sv
module ubf_flags
    import uart_buf_pkg::*;
#(
    parameter bit HAS_DCD = 1'b1
) (
    input  logic       rx_full,
    input  logic       rx_empty,
    input  logic       tx_full,
    input  logic       busy,
    input  logic       dcd_in,
    output logic [7:0] status
);
    logic carrier;

    generate
        if (HAS_DCD) begin : g_dcd
            assign carrier = dcd_in;
        end else begin : g_no_dcd
            logic unused_dcd;
            assign unused_dcd = dcd_in;
            assign carrier    = 1'b0;
        end
    endgenerate

    always_comb begin
        status               = '0;
        status[FLG_RX_FULL]  = rx_full;
        status[FLG_TX_FULL]  = tx_full;
        status[FLG_RX_EMPTY] = rx_empty;
        status[FLG_BUSY]     = busy;
        status[FLG_CARRIER]  = carrier;
    end
endmodule

// File: rtl/uart_buf_flags.sv
module uart_buf_flags #(
    parameter int DEPTH     = 16,
    parameter int BIT_TICKS = 16,
    parameter int STOP_BITS = 1,
    parameter bit HAS_DCD   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       uart_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       dcd_in,
    output logic       txd,
    output logic [7:0] status,
    output logic       overrun
);
    localparam int W = 8;

    typedef struct packed {
        logic mode;
        logic ovr;
    } top_state_t;

    top_state_t t_q, t_d;
    logic flush;
    logic tx_full, tx_empty, tx_drop, tx_take, tx_active;
    logic rx_full, rx_empty, rx_drop;
    logic [W-1:0] tx_head;

    assign flush   = (fifo_en != t_q.mode);
    assign overrun = t_q.ovr;

    ubf_queue #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(!t_q.mode),
        .push(wr_en), .push_data(wr_data), .pop(tx_take),
        .head(tx_head), .full(tx_full), .empty(tx_empty), .push_drop(tx_drop)
    );

    ubf_queue #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(!t_q.mode),
        .push(rx_valid), .push_data(rx_byte), .pop(rd_en),
        .head(rd_data), .full(rx_full), .empty(rx_empty), .push_drop(rx_drop)
    );

    ubf_tx_shift #(.W(W), .BIT_TICKS(BIT_TICKS), .STOP_BITS(STOP_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(uart_en), .avail(!tx_empty && !flush),
        .data(tx_head), .take(tx_take), .active(tx_active), .txd(txd)
    );

    ubf_flags #(.HAS_DCD(HAS_DCD)) u_flags (
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full),
        .busy(tx_active || !tx_empty), .dcd_in(dcd_in), .status(status)
    );

    always_comb begin
        t_d      = t_q;
        t_d.mode = fifo_en;
        if (flush)        t_d.ovr = 1'b0;
        else if (rx_drop) t_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    logic unused_tx_drop;
    assign unused_tx_drop = tx_drop;
endmodule

// File: rtl/uart_buf_flags_chk.sv
module uart_buf_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       flush,
    input logic [7:0] status,
    input logic       txd,
    input logic       overrun
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] == 1'b0) && (status[1:0] == 2'b00));

    a_r3_rx_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[6] && status[4]));

    a_r8_write_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !status[5] && !flush) |=> status[3]);

    a_r8_tx_full_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |-> status[3]);

    a_r10_low_line_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (txd == 1'b0) |-> status[3]);

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (status[4] && !status[6] && !status[5] && !overrun));
endmodule

bind uart_buf_flags uart_buf_flags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flush(flush),
    .status(status), .txd(txd), .overrun(overrun)
);

// File: tb/uart_buf_flags_test.sv
module uart_buf_flags_test;
    localparam int CLK_PERIOD = 10;
    localparam int BT         = 4;
    localparam int DEPTH      = 16;
    localparam int STOPS      = 1;
    localparam int FRAME_CYC  = (9 + STOPS) * BT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, uart_en = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0, dcd_in = 1'b0;
    logic [7:0] wr_data = '0, rx_byte = '0;
    logic [7:0] rd_data, status;
    logic       txd, overrun;
    logic [7:0] rd_data2, status2;
    logic       txd2, overrun2;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_buf_flags #(.DEPTH(DEPTH), .BIT_TICKS(BT), .STOP_BITS(STOPS), .HAS_DCD(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .uart_en(uart_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .dcd_in(dcd_in),
        .txd(txd), .status(status), .overrun(overrun)
    );

    uart_buf_flags #(.DEPTH(DEPTH), .BIT_TICKS(BT), .STOP_BITS(STOPS), .HAS_DCD(1'b0)) uut_nodcd (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .uart_en(uart_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data2),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .dcd_in(dcd_in),
        .txd(txd2), .status(status2), .overrun(overrun2)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: scoreboard push for bytes expected on the line
    task automatic tx_write(input logic [7:0] b, input bit sent);
        wr_en = 1'b1; wr_data = b;
        if (sent) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_read(input logic [7:0] exp, input string req);
        check(req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (status[3]) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: decode serial frames, compare with scoreboard
    initial begin : monitor
        logic [7:0] got;
        logic       stop_v;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (BT/2) @(negedge clk);
                check("R9 start bit mid", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BT) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BT) @(negedge clk);
                stop_v = txd;
                check("R9 stop bit", int'(stop_v), 1);
                if (exp_q.size() == 0) begin
                    check("R9 unexpected byte on line", int'(got), 256);
                end else begin
                    check("R9 frame data order", int'(got), int'(exp_q.pop_front()));
                end
                repeat (BT - BT/2 - 1) @(negedge clk);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 / R1 reset state
        check("R2 status reset", int'(status), 8'h10);
        check("R2 overrun reset", int'(overrun), 0);
        check("R2 txd idle", int'(txd), 1);

        // R11 carrier detect
        dcd_in = 1'b1;
        #1;
        check("R11 carrier bit on", int'(status[2]), 1);
        check("R11 carrier tied off", int'(status2[2]), 0);
        check("R1 status with carrier", int'(status), 8'h14);
        dcd_in = 1'b0;
        @(negedge clk);

        // holding mode, UART disabled
        tx_write(8'hA5, 1'b1);
        check("R3 tx full in holding mode", int'(status[5]), 1);
        check("R8 busy while disabled", int'(status[3]), 1);
        tx_write(8'h11, 1'b0);
        check("R6 tx full persists after dropped write", int'(status[5]), 1);
        repeat (10) @(negedge clk);
        check("R9 line idle while disabled", int'(txd), 1);
        check("R9 busy held while disabled", int'(status[3]), 1);

        rx_push(8'h3C);
        check("R3 rx full in holding mode", int'(status[6]), 1);
        check("R3 rx not empty", int'(status[4]), 0);
        check("R6 no overrun yet", int'(overrun), 0);
        rx_push(8'h77);
        check("R6 overrun set", int'(overrun), 1);
        rx_read(8'h3C, "R6 dropped byte not stored");
        check("R3 rx empty after read", int'(status[4]), 1);
        check("R6 overrun sticky", int'(overrun), 1);

        uart_en = 1'b1;
        wait_idle();
        check("R6 dropped tx byte never sent", exp_q.size(), 0);

        // R10 exact busy length
        tx_write(8'h5A, 1'b1);
        n = 0;
        while (status[3] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check("R10 busy cycles", n, 1 + FRAME_CYC);
        repeat (4) @(negedge clk);
        uart_en = 1'b0;

        // R7 mode change flush
        tx_write(8'h22, 1'b0);
        rx_push(8'h44);
        check("R7 pre-flush status", int'(status), 8'h68);
        check("R7 pre-flush overrun", int'(overrun), 1);
        fifo_en = 1'b1;
        @(negedge clk);
        check("R7 status after flush", int'(status), 8'h10);
        check("R7 overrun cleared", int'(overrun), 0);

        // queue mode
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) check("R4 tx not full below depth", int'(status[5]), 0);
            tx_write(8'h80 + 8'(i), 1'b1);
        end
        check("R4 tx full at depth", int'(status[5]), 1);
        check("R8 busy in queue mode", int'(status[3]), 1);
        tx_write(8'hEE, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 1) check("R4 rx not full below depth", int'(status[6]), 0);
            rx_push(8'h10 + 8'(i));
        end
        check("R4 rx full at depth", int'(status[6]), 1);
        check("R4 rx not empty", int'(status[4]), 0);
        for (int i = 0; i < DEPTH; i++) begin
            rx_read(8'h10 + 8'(i), "R5 receive order");
        end
        check("R5 rx empty after drain", int'(status[4]), 1);
        check("R6 no overrun in queue mode", int'(overrun), 0);

        uart_en = 1'b1;
        wait_idle();
        repeat (BT) @(negedge clk);
        check("R9 all queued bytes sent", exp_q.size(), 0);
        check("R2 idle status at end", int'(status), 8'h10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule